// File: doc/BRIEF.md
# Fast-Lock Charge-Pump Timer

This block sequences the short high-gain phase a fractional-N PLL uses to settle quickly. When the loop is retuned or woken up, it selects the high-current charge pump and closes the loop-filter bypass switch. It holds that state for a programmed number of phase-detector cycles, then returns to the normal pump and opens the switch.

Retuning is signalled by a one-cycle frequency-update strobe, issued when a new frequency word is committed. Wake-up is the PLL power input going from low to high. Both triggers are gated by an arm bit. The period length is a 13-bit count. It advances only on cycles where the PFD-rate enable is high, so one period lasts count × the PFD period. The two current-magnitude codes go straight through to the analog pumps without change.

Top module: `fastlock_timer`

## Requirements
- R1: After reset, `busy`, `pump_fast` and `bypass_on` are 0. A reset release with `pll_pwr_on` already high is not a trigger.
- R2: A frequency-update trigger starts a fast period when all of these hold in the same cycle: `freq_upd`=1, `fast_en`=1, `pll_pwr_on`=1 and `fast_count`≠0. From the next cycle, `busy`, `pump_fast` and `bypass_on` are 1.
- R3: A power-up trigger starts a fast period. This is `pll_pwr_on` sampled 1 in a cycle after it was sampled 0, with `fast_en`=1 in that cycle and `fast_count`≠0. The outputs follow one cycle later, as in R2.
- R4: A fast period started with count N ends after exactly N cycles that have `pfd_tick`=1. Cycles without a tick do not advance it. `busy` falls in the cycle after the Nth tick. A tick in the trigger cycle itself is not counted.
- R5: While `fast_en`=0, neither trigger starts a period. An idle block stays idle. An active period is left to run out.
- R6: A trigger during an active period reloads the full count from `fast_count`. The period restarts from that value.
- R7: `pll_pwr_on`=0 clears any active period from the next cycle. While it stays 0, `freq_upd` has no effect.
- R8: A trigger with `fast_count`=0 gives no fast period. If a period is active, such a trigger ends it in the next cycle.
- R9: `pump_fast` (1 = fast pump, 0 = normal pump) and `bypass_on` are 1 exactly when `busy` is 1.
- R10: `norm_code_o` equals `norm_code_i` (4 bits) and `fast_code_o` equals `fast_code_i` (3 bits) in every cycle, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pfd_tick | input | 1 | One-cycle enable per phase-detector period |
| fast_en | input | 1 | Arms the fast-lock triggers |
| fast_count | input | 13 | Fast period length in PFD cycles (0 = none) |
| freq_upd | input | 1 | One-cycle strobe: new frequency committed |
| pll_pwr_on | input | 1 | PLL power input, 1 = running |
| norm_code_i | input | 4 | Normal pump current code |
| fast_code_i | input | 3 | Fast pump current code |
| pump_fast | output | 1 | Pump select, 1 = fast pump |
| bypass_on | output | 1 | Loop-filter bypass switch closed |
| busy | output | 1 | Fast period in progress |
| norm_code_o | output | 4 | Normal pump current code, passed through |
| fast_code_o | output | 3 | Fast pump current code, passed through |

## Verification
The bench targets off-by-one period lengths. It uses sparse ticks, where a design that counted clocks instead of PFD cycles would end too early. It also places ticks in the trigger cycle, where a design that counted that tick would end one PFD cycle short. It retriggers mid-period, which catches a design that ignores the new trigger or keeps the old remainder. It drops power mid-period while strobing updates, which catches a design that keeps the switch closed on a sleeping loop. The remaining cases are zero-count triggers, disarmed triggers and a reset released with power already high. A wrong design would hold the fast pump forever, fire while disarmed, or start a spurious period at start-up.

// File: rtl/fl_pkg.sv
// Shared types and constants for the fast-lock timer.
// Assumes: single clock domain, pump select encoded as one bit.
package fl_pkg;
    typedef enum logic {
        PUMP_NORMAL = 1'b0,
        PUMP_FAST   = 1'b1
    } pump_sel_e;

    localparam int DEF_CNT_W   = 13;
    localparam int DEF_NCODE_W = 4;
    localparam int DEF_FCODE_W = 3;
endpackage

// File: rtl/fl_trigger.sv
// Trigger qualifier: combines the frequency-update strobe and the
// power-input rising edge into one start pulse, gated by the arm bit.
// Assumes: freq_upd is a single-cycle strobe; pwr_on is synchronous.
// The edge history resets to "powered" so reset release is never an edge.
module fl_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_en,
    input  logic pwr_on,
    input  logic upd_stb,
    output logic fire
);
    logic pwr_prev;
    logic pwr_rise;

    // Remember the power input from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pwr_prev <= 1'b1;
        else        pwr_prev <= pwr_on;
    end

    // Detect a start condition in the current cycle.
    always_comb begin
        pwr_rise = pwr_on & ~pwr_prev;
        fire     = arm_en & pwr_on & (upd_stb | pwr_rise);
    end
endmodule

// File: rtl/fl_period.sv
// Period counter: loads the programmed count on a start pulse and
// decrements once per PFD tick until it reaches zero.
// Assumes: a start pulse takes priority over a tick in the same cycle;
// a zero load means no period. Power-off clears the count.
module fl_period #(
    parameter int CNT_W = fl_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             pwr_on,
    input  logic             tick,
    input  logic [CNT_W-1:0] load_val,
    output logic             active
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] remain;

    // Hold the number of PFD ticks left in the fast period.
    always_ff @(posedge clk) begin
        if (!rst_n)                       remain <= ZERO;
        else if (fire)                    remain <= load_val;
        else if (!pwr_on)                 remain <= ZERO;
        else if (tick && remain != ZERO)  remain <= remain - ONE;
    end

    // A nonzero remainder means the fast phase is in progress.
    always_comb active = (remain != ZERO);
endmodule

// File: rtl/fl_drive.sv
// Output stage: turns the active flag into pump select and switch
// controls, and passes the current codes through untouched.
// Assumes: switch and pump select share one timing source.
module fl_drive #(
    parameter int NCODE_W = fl_pkg::DEF_NCODE_W,
    parameter int FCODE_W = fl_pkg::DEF_FCODE_W
) (
    input  logic               active,
    input  logic [NCODE_W-1:0] ncode_in,
    input  logic [FCODE_W-1:0] fcode_in,
    output logic               sel_fast,
    output logic               sw_close,
    output logic               in_fast,
    output logic [NCODE_W-1:0] ncode_out,
    output logic [FCODE_W-1:0] fcode_out
);
    fl_pkg::pump_sel_e sel;

    // Pick the pump and switch state from the active flag.
    always_comb begin
        sel       = active ? fl_pkg::PUMP_FAST : fl_pkg::PUMP_NORMAL;
        sel_fast  = (sel == fl_pkg::PUMP_FAST);
        sw_close  = active;
        in_fast   = active;
        ncode_out = ncode_in;
        fcode_out = fcode_in;
    end
endmodule

// File: rtl/fastlock_timer.sv
// Fast-lock charge-pump timer top level.
// After a committed retune or a power-up edge, and only when armed, it
// selects the fast pump and closes the loop-filter bypass for
// fast_count PFD cycles. Assumes synchronous inputs and a one-cycle
// pfd_tick per PFD period.
module fastlock_timer #(
    parameter int CNT_W   = fl_pkg::DEF_CNT_W,
    parameter int NCODE_W = fl_pkg::DEF_NCODE_W,
    parameter int FCODE_W = fl_pkg::DEF_FCODE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pfd_tick,
    input  logic               fast_en,
    input  logic [CNT_W-1:0]   fast_count,
    input  logic               freq_upd,
    input  logic               pll_pwr_on,
    input  logic [NCODE_W-1:0] norm_code_i,
    input  logic [FCODE_W-1:0] fast_code_i,
    output logic               pump_fast,
    output logic               bypass_on,
    output logic               busy,
    output logic [NCODE_W-1:0] norm_code_o,
    output logic [FCODE_W-1:0] fast_code_o
);
    logic fire;
    logic active;

    fl_trigger u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_en  (fast_en),
        .pwr_on  (pll_pwr_on),
        .upd_stb (freq_upd),
        .fire    (fire)
    );

    fl_period #(.CNT_W(CNT_W)) u_period (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .pwr_on   (pll_pwr_on),
        .tick     (pfd_tick),
        .load_val (fast_count),
        .active   (active)
    );

    fl_drive #(.NCODE_W(NCODE_W), .FCODE_W(FCODE_W)) u_drive (
        .active    (active),
        .ncode_in  (norm_code_i),
        .fcode_in  (fast_code_i),
        .sel_fast  (pump_fast),
        .sw_close  (bypass_on),
        .in_fast   (busy),
        .ncode_out (norm_code_o),
        .fcode_out (fast_code_o)
    );
endmodule

// File: rtl/fastlock_timer_chk.sv
// Property checker for the fast-lock timer, attached by bind.
// Assumes: observes top-level ports only.
module fastlock_timer_chk #(
    parameter int CNT_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pfd_tick,
    input logic             fast_en,
    input logic [CNT_W-1:0] fast_count,
    input logic             freq_upd,
    input logic             pll_pwr_on,
    input logic             pump_fast,
    input logic             bypass_on,
    input logic             busy
);
    // R7: power-off clears the period.
    assert_pwr_off_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_pwr_on |=> !busy);

    // R2: an armed update with nonzero count starts a period.
    assert_update_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_upd && fast_en && pll_pwr_on && fast_count != '0) |=> busy);

    // R5: a disarmed idle block stays idle.
    assert_disarmed_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !fast_en) |=> !busy);

    // R4: without a tick, an active period persists.
    assert_no_tick_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pfd_tick && pll_pwr_on && fast_count != '0) |=> busy);

    // R8: a zero-count trigger leaves the normal pump selected.
    assert_zero_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_upd && fast_en && pll_pwr_on && fast_count == '0) |=> !busy);

    // R9: pump select and switch track the busy flag.
    assert_outputs_agree_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_fast == busy) && (bypass_on == busy));
endmodule

bind fastlock_timer fastlock_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pfd_tick   (pfd_tick),
    .fast_en    (fast_en),
    .fast_count (fast_count),
    .freq_upd   (freq_upd),
    .pll_pwr_on (pll_pwr_on),
    .pump_fast  (pump_fast),
    .bypass_on  (bypass_on),
    .busy       (busy)
);

// File: tb/fastlock_timer_bench.sv
// Self-checking bench with a behavioural reference model compared every cycle.
module fastlock_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pfd_tick = 1'b0;
    logic        fast_en = 1'b0;
    logic [12:0] fast_count = 13'd0;
    logic        freq_upd = 1'b0;
    logic        pll_pwr_on = 1'b1;
    logic [3:0]  norm_code_i = 4'd0;
    logic [2:0]  fast_code_i = 3'd0;
    logic        pump_fast, bypass_on, busy;
    logic [3:0]  norm_code_o;
    logic [2:0]  fast_code_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int model_rem = 0;
    bit model_prev = 1;

    always #4 clk = ~clk;

    fastlock_timer u_fastlock_timer (
        .clk(clk), .rst_n(rst_n), .pfd_tick(pfd_tick), .fast_en(fast_en),
        .fast_count(fast_count), .freq_upd(freq_upd), .pll_pwr_on(pll_pwr_on),
        .norm_code_i(norm_code_i), .fast_code_i(fast_code_i),
        .pump_fast(pump_fast), .bypass_on(bypass_on), .busy(busy),
        .norm_code_o(norm_code_o), .fast_code_o(fast_code_o)
    );

    // Reference model from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            model_rem  = 0;
            model_prev = 1;
        end else begin
            if (fast_en && pll_pwr_on && (freq_upd || !model_prev))
                model_rem = int'(fast_count);
            else if (!pll_pwr_on)
                model_rem = 0;
            else if (pfd_tick && model_rem > 0)
                model_rem = model_rem - 1;
            model_prev = pll_pwr_on;
        end
    end

    task automatic chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Advance one cycle and compare all outputs with the model.
    task automatic step(input string tag);
        bit e;
        @(posedge clk);
        @(negedge clk);
        e = (model_rem > 0);
        chk(tag, int'(busy), int'(e), "busy");
        chk("R9", int'(pump_fast), int'(e), "pump_fast");
        chk("R9", int'(bypass_on), int'(e), "bypass_on");
        chk("R10", int'(norm_code_o), int'(norm_code_i), "norm_code");
        chk("R10", int'(fast_code_o), int'(fast_code_i), "fast_code");
        freq_upd = 1'b0;
    endtask

    task automatic run(input string tag, input int n, input int tick_every);
        for (int i = 0; i < n; i++) begin
            pfd_tick = (tick_every > 0) && (i % tick_every == 0);
            step(tag);
        end
        pfd_tick = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        step("R1");
        step("R1");
        chk("R1", int'(busy), 0, "busy in reset");
        rst_n = 1'b1;
        fast_en = 1'b1;
        fast_count = 13'd4;
        run("R1", 3, 1);
        chk("R1", int'(busy), 0, "no trigger at reset release");

        // R2 and R4: update with every-cycle ticks, tick in trigger cycle
        norm_code_i = 4'd9; fast_code_i = 3'd5;
        freq_upd = 1'b1; pfd_tick = 1'b1;
        step("R2");
        chk("R2", int'(busy), 1, "busy after update");
        run("R4", 6, 1);

        // R4: sparse ticks
        fast_count = 13'd5;
        freq_upd = 1'b1;
        step("R2");
        run("R4", 30, 4);
        chk("R4", int'(busy), 0, "period over");

        // R6: retrigger mid-period
        fast_count = 13'd6;
        freq_upd = 1'b1;
        step("R2");
        run("R6", 8, 2);
        fast_count = 13'd3;
        freq_upd = 1'b1;
        step("R6");
        run("R6", 10, 2);

        // R5: disarmed
        fast_en = 1'b0;
        fast_count = 13'd7;
        freq_upd = 1'b1;
        step("R5");
        chk("R5", int'(busy), 0, "disarmed update");
        pll_pwr_on = 1'b0; step("R5");
        pll_pwr_on = 1'b1; step("R5");
        chk("R5", int'(busy), 0, "disarmed wake");
        run("R5", 3, 1);

        // R3: power-up trigger
        fast_en = 1'b1;
        pll_pwr_on = 1'b0; step("R7");
        pll_pwr_on = 1'b1; step("R3");
        chk("R3", int'(busy), 1, "wake trigger");
        run("R3", 12, 2);

        // R7: power-off mid-period, updates ignored while off
        freq_upd = 1'b1;
        step("R2");
        run("R7", 3, 0);
        pll_pwr_on = 1'b0;
        step("R7");
        chk("R7", int'(busy), 0, "cleared by power-off");
        freq_upd = 1'b1; step("R7");
        freq_upd = 1'b1; step("R7");
        chk("R7", int'(busy), 0, "update while off");
        pll_pwr_on = 1'b1; fast_count = 13'd2;
        run("R7", 8, 1);

        // R8: zero count, idle and while busy
        fast_count = 13'd0;
        freq_upd = 1'b1; step("R8");
        chk("R8", int'(busy), 0, "zero count idle");
        fast_count = 13'd10;
        freq_upd = 1'b1; step("R2");
        run("R8", 3, 1);
        fast_count = 13'd0;
        freq_upd = 1'b1; step("R8");
        chk("R8", int'(busy), 0, "zero count ends period");

        // R4: maximum count
        fast_count = 13'd8191;
        freq_upd = 1'b1; step("R2");
        run("R4", 8195, 1);
        chk("R4", int'(busy), 0, "max count over");

        // R10: codes pass through
        for (int k = 0; k < 8; k++) begin
            norm_code_i = 4'(k * 2 + 1);
            fast_code_i = 3'(k);
            #1;
            chk("R10", int'(norm_code_o), int'(norm_code_i), "norm passthrough");
            chk("R10", int'(fast_code_o), int'(fast_code_i), "fast passthrough");
        end
        step("R10");
        done = 1;
    end

    initial begin
        for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule